// File: doc/BRIEF.md
# Write-Aware Data Bus Drive Control

This block decides, cycle by cycle, whether a common-I/O synchronous memory may turn on the tri-state drivers of its shared data and parity pins. It follows the operation the memory has registered at each enabled clock edge (read, write, idle, or continuation of the previous operation) and combines that with an active-low output enable pin that acts without a clock. The single drive-enable bit it produces gates all eighteen data and parity drivers together.

The block keeps the memory off the bus whenever another agent could be driving it: throughout the cycle in which write data is accepted, while the device is idle (deselected), and for the first enabled cycle after it leaves the idle state. Outside those windows the output enable pin keeps full, asynchronous control. A hold input freezes the registered state without idling the device, so a stretched cycle keeps its drive decision.

Top module: `bus_drive_ctl`

## Requirements
- R1: While reset is low, and after reset until an operation is registered, `drv_en` is 0; reset leaves the block in the idle state, so the first read after reset counts as leaving idle.
- R2: `oe_n` high forces `drv_en` to 0 within the same cycle, with no clock edge needed; `oe_n` low only permits driving.
- R3: A read (`bus_cmd` = 2'b01) registered at an enabled edge, when the block was not idle before that edge, gives `drv_en` equal to the inverse of `oe_n` during the following cycle.
- R4: A write (`bus_cmd` = 2'b10) registered at an enabled edge gives `drv_en` = 0 for the following cycle whatever `oe_n` is.
- R5: An idle command (`bus_cmd` = 2'b00) registered at an enabled edge gives `drv_en` = 0 from that edge on, whatever `oe_n` is.
- R6: The first `WAKE_CYCLES` enabled cycles (default 1) after the registered operation changes from idle to read or write are masked: `drv_en` stays 0 regardless of `oe_n`.
- R7: With `clk_hold` = 1 at an edge, the registered operation and the wake mask are unchanged, so the drive decision of the previous cycle stands (still gated by `oe_n`).
- R8: The continue command (`bus_cmd` = 2'b11) repeats the previously registered operation type: a read stays a read, a write stays a write, and idle stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hold | input | 1 | 1 = ignore this edge and keep all state |
| bus_cmd | input | 2 | Operation at this edge: 00 idle, 01 read, 10 write, 11 continue |
| oe_n | input | 1 | Active-low output enable, combinational |
| drv_en | output | 1 | Drive enable for all data and parity tri-state buffers |

## Verification
The bench targets the transitions where a drive decision flips: write to read with no idle between (a design that treated it as a wake-up would lose the read data), idle to read (a design without the wake mask would drive into a bus still being released), and continue after idle (a design that decoded continue as read would drive while deselected). Hold cycles are placed inside the wake window and inside a write data phase; a design that advanced its state on a held edge would unmask too early or end the write phase while data is still on the pins. The output enable pin is toggled in the middle of cycles to show it cuts the drivers without waiting for a clock.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_RD   = 2'b01,
      OP_WR   = 2'b10,
      OP_CONT = 2'b11
   } bus_op_e;
endpackage

// File: rtl/bdc_op_reg.sv
module bdc_op_reg
   import bdc_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    adv,
   input  bus_op_e cmd,
   output bus_op_e op_q,
   output bus_op_e op_nxt
);
   // Continue keeps the type latched at the start of the sequence.
   always_comb begin
      op_nxt = (cmd == OP_CONT) ? op_q : cmd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   op_q <= OP_IDLE;
      else if (adv) op_q <= op_nxt;
   end
endmodule

// File: rtl/bdc_wake_mask.sv
module bdc_wake_mask
   import bdc_pkg::*;
#(
   parameter int WAKE_CYCLES = 1
)(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    adv,
   input  bus_op_e op_q,
   input  bus_op_e op_nxt,
   output logic    mask
);
   localparam int CNT_W = $clog2(WAKE_CYCLES + 1);

   logic leaving_idle;
   assign leaving_idle = (op_q == OP_IDLE) && (op_nxt != OP_IDLE);

   generate
      if (WAKE_CYCLES < 1) begin : g_bad_param
         $error("bdc_wake_mask: WAKE_CYCLES must be at least 1");
      end

      if (WAKE_CYCLES == 1) begin : g_single
         logic mask_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   mask_q <= 1'b0;
            else if (adv) mask_q <= leaving_idle;
         end
         assign mask = mask_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (adv) begin
               if (op_nxt == OP_IDLE)  cnt_q <= '0;
               else if (leaving_idle)  cnt_q <= CNT_W'(WAKE_CYCLES);
               else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
            end
         end
         assign mask = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/bdc_gate.sv
module bdc_gate
   import bdc_pkg::*;
(
   input  bus_op_e op_q,
   input  logic    mask,
   input  logic    oe_n,
   output logic    drv_en
);
   // Internal permission is registered; the pin enable is applied last.
   logic permit;
   always_comb begin
      permit = (op_q == OP_RD) && !mask;
      drv_en = permit && !oe_n;
   end
endmodule

// File: rtl/bus_drive_ctl.sv
module bus_drive_ctl
   import bdc_pkg::*;
#(
   parameter int WAKE_CYCLES = 1
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clk_hold,
   input  logic [1:0] bus_cmd,
   input  logic       oe_n,
   output logic       drv_en
);
   bus_op_e op_q;
   bus_op_e op_nxt;
   logic    mask;
   logic    adv;

   assign adv = !clk_hold;

   bdc_op_reg u_op (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .cmd    (bus_op_e'(bus_cmd)),
      .op_q   (op_q),
      .op_nxt (op_nxt)
   );

   bdc_wake_mask #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .op_q   (op_q),
      .op_nxt (op_nxt),
      .mask   (mask)
   );

   bdc_gate u_gate (
      .op_q   (op_q),
      .mask   (mask),
      .oe_n   (oe_n),
      .drv_en (drv_en)
   );
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
   parameter int WAKE_CYCLES = 1
)(
   input logic       clk,
   input logic       rst_n,
   input logic       clk_hold,
   input logic [1:0] bus_cmd,
   input logic       oe_n,
   input logic       drv_en
);
   logic go_idle, go_rd, go_wr, go_cont;
   assign go_idle = !clk_hold && (bus_cmd == 2'b00);
   assign go_rd   = !clk_hold && (bus_cmd == 2'b01);
   assign go_wr   = !clk_hold && (bus_cmd == 2'b10);
   assign go_cont = !clk_hold && (bus_cmd == 2'b11);

   p_quiet_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> !drv_en);

   p_oe_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drv_en);

   p_write_phase_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      go_wr |=> !drv_en);

   p_idle_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go_idle |=> !drv_en);

   p_wake_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      go_idle ##1 (go_rd || go_wr) |=> !drv_en);

   p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clk_hold |=> ($stable(drv_en) || !$stable(oe_n)));

   p_cont_write_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go_wr ##1 go_cont |=> !drv_en);

   p_cont_idle_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      go_idle ##1 go_cont |=> !drv_en);

   generate
      if (WAKE_CYCLES == 1) begin : g_rd_chk
         p_read_follows_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
            go_rd ##1 go_rd |=> (drv_en == !oe_n));
      end
   endgenerate
endmodule

bind bus_drive_ctl bdc_checker #(.WAKE_CYCLES(WAKE_CYCLES)) u_bdc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_hold (clk_hold),
   .bus_cmd  (bus_cmd),
   .oe_n     (oe_n),
   .drv_en   (drv_en)
);

// File: tb/tb_bus_drive_ctl.sv
module tb_bus_drive_ctl;
   localparam int WAKE = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_hold = 1'b0;
   logic [1:0] bus_cmd = 2'b00;
   logic       oe_n = 1'b0;
   logic       drv_en;

   int checks = 0;
   int fails = 0;
   int edge_cnt = 0;
   bit done = 1'b0;

   // reference state
   logic [1:0] m_op = 2'b00;
   int         m_cnt = 0;
   bit         cur_perm = 1'b0;

   bit    perm_q[$];
   int    due_q[$];
   string tag_q[$];

   bus_drive_ctl #(.WAKE_CYCLES(WAKE)) dut (
      .clk(clk), .rst_n(rst_n), .clk_hold(clk_hold),
      .bus_cmd(bus_cmd), .oe_n(oe_n), .drv_en(drv_en)
   );

   always #5 clk = ~clk;
   always @(posedge clk) edge_cnt <= edge_cnt + 1;

   task automatic check(input string tag, input bit act, input bit exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: drv_en=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: set inputs for the next edge and push the expected permission
   task automatic apply(input logic [1:0] c, input bit h, input bit oe, input string tag);
      logic [1:0] nxt;
      @(posedge clk);
      #1;
      bus_cmd = c; clk_hold = h; oe_n = oe;
      if (!h) begin
         nxt = (c == 2'b11) ? m_op : c;
         if (nxt == 2'b00)      m_cnt = 0;
         else if (m_op == 2'b00) m_cnt = WAKE;
         else if (m_cnt > 0)     m_cnt = m_cnt - 1;
         m_op = nxt;
      end
      perm_q.push_back((m_op == 2'b01) && (m_cnt == 0));
      due_q.push_back(edge_cnt + 1);
      tag_q.push_back(tag);
   endtask

   // mid-cycle toggle of the output enable, R2
   task automatic async_oe(input bit v);
      bit saved;
      #5;
      saved = oe_n;
      oe_n = v;
      #1;
      check("R2", drv_en, cur_perm && !v);
      oe_n = saved;
   endtask

   // monitor: compare once the edge an item belongs to has passed
   initial begin
      forever begin
         @(posedge clk);
         #4;
         if (due_q.size() > 0 && due_q[0] == edge_cnt) begin
            void'(due_q.pop_front());
            cur_perm = perm_q.pop_front();
            check(tag_q.pop_front(), drv_en, cur_perm && !oe_n);
         end
      end
   end

   initial begin
      #50000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: run hung, actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] lf;
      repeat (2) @(posedge clk);
      #1;
      check("R1", drv_en, 1'b0);
      rst_n = 1'b1;
      #1;
      check("R1", drv_en, 1'b0);

      apply(2'b01, 0, 0, "R1");     // first read after reset is masked
      apply(2'b01, 0, 0, "R3");
      apply(2'b01, 0, 1, "R2");
      apply(2'b01, 0, 0, "R3");
      async_oe(1'b1);
      apply(2'b10, 0, 0, "R4");
      apply(2'b11, 0, 0, "R8");     // write continues
      apply(2'b01, 0, 0, "R3");     // write to read: no wake mask
      async_oe(1'b1);
      apply(2'b01, 0, 0, "R3");
      async_oe(1'b0);
      apply(2'b00, 0, 0, "R5");
      apply(2'b11, 0, 0, "R8");     // continue while idle stays idle
      apply(2'b01, 0, 0, "R6");
      apply(2'b01, 0, 0, "R6");
      apply(2'b00, 0, 0, "R5");
      apply(2'b01, 1, 0, "R7");     // held: still idle
      apply(2'b01, 1, 0, "R7");
      apply(2'b01, 0, 0, "R6");     // wake cycle
      apply(2'b10, 1, 0, "R7");     // held inside wake: mask kept
      apply(2'b11, 0, 0, "R8");     // read continues, mask consumed
      apply(2'b10, 1, 0, "R7");     // held while driving
      apply(2'b10, 0, 0, "R4");
      apply(2'b01, 1, 0, "R7");     // write data phase stretched
      apply(2'b10, 0, 1, "R4");
      apply(2'b00, 0, 1, "R5");
      apply(2'b10, 0, 0, "R6");     // write out of idle
      apply(2'b01, 0, 0, "R3");

      lf = 8'hA5;
      for (int i = 0; i < 60; i++) begin
         lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
         apply(lf[1:0], lf[7:5] == 3'b000, lf[4] & lf[3], "R3");
      end
      apply(2'b00, 0, 0, "R5");
      repeat (3) @(posedge clk);
      #6;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule